// File: doc/BRIEF.md
# Gated Frequency Counter Sequencer

This block runs the measurement cycle of a gated frequency counter from a single reference clock. A chain of prescalers divides the reference clock into a base tick and a series of slower ticks, one per gate range. The selected tick drives a 4-bit phase counter that cycles through all sixteen values. A few of those values are decoded into control events. Phase 0 clears the event counter. Phase 2 opens the measurement gate. Phase 12 closes it. Phase 14 copies the count into the result register. The gate therefore stays open for exactly ten ticks, which is one selected gate time. A full cycle takes sixteen ticks.

The signal under test is assumed to be already conditioned to logic levels. It passes through a two-flop synchronizer, and only its rising edges that arrive while the gate is open are counted. The result register holds its value from one store to the next. When the count would pass its maximum, it stops at full scale and sets a flag that is stored with it. With the default parameters, the tick period for range k is `BASE_DIV * STEP_RATIO**k` reference cycles, written P below. With a 50 MHz reference this gives gates of 1 ms up to 100 s in decade steps. The result is then the input frequency scaled by the gate length, with an inherent uncertainty of one count.

Top module: `freq_gate_sequencer`

## Requirements
- R1: While `rst_n` is low, `clear_o`, `gate_o`, `store_o`, `result_o`, `result_ovf_o` and `phase_o` are all 0.
- R2: The phase counter steps by one on each selected tick and wraps from 15 to 0. `clear_o` pulses as phase 0 is entered, and `gate_o` rises 2P cycles later. `store_o` pulses 14P cycles after the clear, while `phase_o` reads 14. Consecutive stores are 16P cycles apart.
- R3: `gate_o` stays high for exactly 10P consecutive cycles. For `gate_sel` codes 0 to 5, P = `BASE_DIV * STEP_RATIO**gate_sel`.
- R4: `gate_sel` codes 6 and 7 select the automatic range, which behaves exactly like code 3.
- R5: Each rising edge of `sig_in` that is synchronized while the gate is open adds one to the count. For an input with period T cycles, the stored result is floor(10P/T) or ceil(10P/T).
- R6: Edges of `sig_in` while the gate is closed do not change the count. Input activity confined to the closed part of the cycle stores a result of 0.
- R7: The count saturates at 2^CNT_W-1. An edge that arrives at full scale sets the overflow flag, and `result_ovf_o` takes that flag at each store.
- R8: `result_o` and `result_ovf_o` change only on the cycle after a `store_o` pulse and hold their values otherwise.
- R9: A change of `gate_sel` and the first cycle after reset both restart the cycle. On the next cycle `clear_o` is 1, `gate_o` is 0 and `phase_o` is 0, and the prescalers start from zero.
- R10: `clear_o` and `store_o` are single-cycle pulses that never coincide, and `gate_o` is low whenever `store_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_sel | input | 3 | Gate range code; 0..5 ranges, 6/7 automatic |
| sig_in | input | 1 | Conditioned signal under test (asynchronous) |
| clear_o | output | 1 | Event counter clear pulse |
| gate_o | output | 1 | Gate open level |
| store_o | output | 1 | Result store strobe |
| phase_o | output | 4 | Current phase counter value |
| result_o | output | CNT_W | Stored event count |
| result_ovf_o | output | 1 | Stored saturation flag |

## Verification
The bench uses a small prescaler ratio so that every gate code can be swept. Intervals between events are measured at the ports. A sequencer that decoded the wrong phase would give a clear-to-gate, gate-width or store spacing that does not match 2P, 10P or 16P. Counts are compared with the floor/ceil bound for several input periods. An off-by-one in the synchronizer or the edge detector, or counting outside the window, shows up as an out-of-bound result. The same happens when input activity is confined to the closed phases, which must store zero. A fast input over a long gate must pin the result at full scale and set the flag. Results are also checked to hold between strobes and to restart on a range change.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
  localparam int unsigned PH_W     = 4;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NRANGE   = 6;
  localparam int unsigned AUTO_IDX = 3;

  localparam logic [PH_W-1:0] PH_CLEAR = 4'd0;
  localparam logic [PH_W-1:0] PH_OPEN  = 4'd2;
  localparam logic [PH_W-1:0] PH_CLOSE = 4'd12;
  localparam logic [PH_W-1:0] PH_STORE = 4'd14;

  // Map a gate code to a range index; codes past the last range pick auto.
  function automatic logic [SEL_W-1:0] sel_to_idx(input logic [SEL_W-1:0] sel);
    if (sel >= SEL_W'(NRANGE)) return SEL_W'(AUTO_IDX);
    return sel;
  endfunction
endpackage

// File: rtl/fgs_timebase.sv
module fgs_timebase
  import fgs_pkg::*;
#(
  parameter int unsigned BASE_DIV   = 5000,
  parameter int unsigned STEP_RATIO = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int unsigned DW = (STEP_RATIO > 1) ? $clog2(STEP_RATIO) : 1;

  logic [NRANGE-1:0] tk;
  logic [BW-1:0]     bcnt;
  logic [SEL_W-1:0]  idx;

  assign tk[0] = (bcnt == BW'(BASE_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bcnt <= '0;
    else if (restart) bcnt <= '0;
    else if (tk[0])   bcnt <= '0;
    else              bcnt <= bcnt + 1'b1;
  end

  for (genvar k = 1; k < NRANGE; k++) begin : g_stage
    logic [DW-1:0] dcnt;
    assign tk[k] = tk[k-1] && (dcnt == DW'(STEP_RATIO - 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dcnt <= '0;
      else if (restart) dcnt <= '0;
      else if (tk[k])   dcnt <= '0;
      else if (tk[k-1]) dcnt <= dcnt + 1'b1;
    end
  end

  assign idx  = sel_to_idx(sel);
  assign tick = tk[idx] && !restart;
endmodule

// File: rtl/fgs_phase_seq.sv
module fgs_phase_seq
  import fgs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             tick,
  output logic             restart,
  output logic [SEL_W-1:0] sel_q,
  output logic [PH_W-1:0]  phase,
  output logic             clear,
  output logic             gate,
  output logic             store
);
  logic            started;
  logic [PH_W-1:0] nxt;

  assign restart = !started || (sel_in != sel_q);
  assign nxt     = phase + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      sel_q   <= '0;
      phase   <= PH_CLEAR;
      clear   <= 1'b0;
      gate    <= 1'b0;
      store   <= 1'b0;
    end else if (restart) begin
      started <= 1'b1;
      sel_q   <= sel_in;
      phase   <= PH_CLEAR;
      clear   <= 1'b1;
      gate    <= 1'b0;
      store   <= 1'b0;
    end else if (tick) begin
      phase <= nxt;
      clear <= (nxt == PH_CLEAR);
      store <= (nxt == PH_STORE);
      if (nxt == PH_OPEN)       gate <= 1'b1;
      else if (nxt == PH_CLOSE) gate <= 1'b0;
    end else begin
      clear <= 1'b0;
      store <= 1'b0;
    end
  end

  AST_CLEAR_STORE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && store)); // R10
  AST_GATE_SHUT_AT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> !gate); // R10
  AST_STORE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> (phase == PH_STORE)); // R2
  AST_GATE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (phase >= PH_OPEN && phase < PH_CLOSE)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (phase == $past(phase) + 4'd1)); // R2
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (clear && !gate && phase == PH_CLEAR)); // R9
endmodule

// File: rtl/fgs_event_counter.sv
module fgs_event_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             clear,
  input  logic             gate,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic s1, s2, s3, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sig_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 && !s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (gate && rise) begin
      if (count == CNT_MAX) ovf <= 1'b1;
      else                  count <= count + 1'b1;
    end
  end

  AST_IDLE_WHEN_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !clear) |=> $stable(count)); // R6
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clear) |=> (count == CNT_MAX)); // R7
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == CNT_MAX)); // R7
endmodule

// File: rtl/fgs_result_latch.sv
module fgs_result_latch #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store,
  input  logic [CNT_W-1:0] count,
  input  logic             ovf,
  output logic [CNT_W-1:0] result,
  output logic             result_ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_ovf <= 1'b0;
    end else if (store) begin
      result     <= count;
      result_ovf <= ovf;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !store |=> ($stable(result) && $stable(result_ovf))); // R8
endmodule

// File: rtl/freq_gate_sequencer.sv
module freq_gate_sequencer
  import fgs_pkg::*;
#(
  parameter int unsigned BASE_DIV   = 5000,
  parameter int unsigned STEP_RATIO = 10,
  parameter int unsigned CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       gate_sel,
  input  logic             sig_in,
  output logic             clear_o,
  output logic             gate_o,
  output logic             store_o,
  output logic [3:0]       phase_o,
  output logic [CNT_W-1:0] result_o,
  output logic             result_ovf_o
);
  logic             restart, tick, ovf;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] count;

  fgs_phase_seq u_seq (
    .clk, .rst_n, .sel_in(gate_sel), .tick, .restart, .sel_q,
    .phase(phase_o), .clear(clear_o), .gate(gate_o), .store(store_o)
  );

  fgs_timebase #(.BASE_DIV(BASE_DIV), .STEP_RATIO(STEP_RATIO)) u_tb (
    .clk, .rst_n, .restart, .sel(sel_q), .tick
  );

  fgs_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .sig_in, .clear(clear_o), .gate(gate_o), .count, .ovf
  );

  fgs_result_latch #(.CNT_W(CNT_W)) u_lat (
    .clk, .rst_n, .store(store_o), .count, .ovf,
    .result(result_o), .result_ovf(result_ovf_o)
  );
endmodule

// File: tb/freq_gate_sequencer_bench.sv
module freq_gate_sequencer_bench;
  localparam int BASE = 2;
  localparam int STEP = 3;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] gate_sel = 3'd0;
  logic sig_in = 1'b0;
  logic clear_o, gate_o, store_o, result_ovf_o;
  logic [3:0] phase_o;
  logic [CW-1:0] result_o;

  int errors = 0, checks = 0;
  int cyc = 0;
  int tin = 0;
  int gmode = 0;
  int ph = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  freq_gate_sequencer #(.BASE_DIV(BASE), .STEP_RATIO(STEP), .CNT_W(CW)) u_freq_gate_sequencer (
    .clk, .rst_n, .gate_sel, .sig_in, .clear_o, .gate_o, .store_o,
    .phase_o, .result_o, .result_ovf_o
  );

  // Stimulus: one rising edge every tin cycles; mode 1 only in closed phases 13..15, 0.
  always @(negedge clk) begin
    if (tin > 0 && (gmode == 0 || phase_o >= 4'd13 || phase_o == 4'd0)) begin
      sig_in <= (ph < (tin + 1) / 2);
      ph <= (ph + 1 >= tin) ? 0 : ph + 1;
    end else begin
      sig_in <= 1'b0;
      ph <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int sel);
    int idx = (sel >= 6) ? 3 : sel;
    int p = BASE;
    for (int k = 0; k < idx; k++) p = p * STEP;
    return p;
  endfunction

  task automatic measure(input int sel, input int t, input int mode);
    int p, tc, tg, tf, ts, ts2, lo, hi, held;
    bit stable;
    p = period_of(sel);
    @(negedge clk);
    gate_sel = 3'(sel);
    tin = t;
    gmode = mode;
    ph = 0;
    @(negedge clk);
    // R9: restart one cycle after a code change
    check(clear_o == 1'b1 && gate_o == 1'b0 && phase_o == 4'd0, "R9", int'(clear_o), 1);
    tc = cyc;
    @(negedge clk);
    check(clear_o == 1'b0, "R10 clear width", int'(clear_o), 0);
    while (!gate_o) @(negedge clk);
    tg = cyc;
    check(tg - tc == 2 * p, "R2 clear-to-open", tg - tc, 2 * p);
    while (gate_o) @(negedge clk);
    tf = cyc;
    check(tf - tg == 10 * p, (sel >= 6) ? "R4 auto gate width" : "R3 gate width", tf - tg, 10 * p);
    while (!store_o) @(negedge clk);
    ts = cyc;
    check(ts - tc == 14 * p, "R2 clear-to-store", ts - tc, 14 * p);
    check(phase_o == 4'd14 && !gate_o, "R2 store phase", int'(phase_o), 14);
    @(negedge clk);
    check(store_o == 1'b0, "R10 store width", int'(store_o), 0);
    if (mode == 1 || t == 0) begin
      lo = 0; hi = 0;
    end else begin
      lo = (10 * p) / t;
      hi = lo + (((10 * p) % t) != 0 ? 1 : 0);
    end
    if (lo > CMAX) begin
      check(int'(result_o) == CMAX && result_ovf_o, "R7 saturation", int'(result_o), CMAX);
    end else begin
      check(int'(result_o) >= lo && int'(result_o) <= hi && !result_ovf_o,
            (mode == 1) ? "R6 closed-gate edges" : "R5 count bound", int'(result_o), lo);
    end
    held = int'(result_o);
    stable = 1'b1;
    while (!store_o) begin
      if (int'(result_o) != held) stable = 1'b0;
      @(negedge clk);
    end
    ts2 = cyc;
    check(stable, "R8 result hold", int'(result_o), held);
    check(ts2 - ts == 16 * p, "R2 store spacing", ts2 - ts, 16 * p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(!clear_o && !gate_o && !store_o, "R1 controls", int'(gate_o), 0);
    check(result_o == '0 && !result_ovf_o && phase_o == 4'd0, "R1 result", int'(result_o), 0);
    rst_n = 1'b1;
    measure(1, 4, 0);
    measure(0, 3, 0);
    measure(2, 5, 0);
    measure(3, 7, 0);
    measure(6, 9, 0);
    measure(7, 6, 0);
    measure(4, 11, 0);
    measure(5, 13, 0);
    measure(3, 2, 0);
    measure(2, 3, 1);
    measure(1, 0, 0);
    measure(0, 2, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule